// File: doc/BRIEF.md
# Serial EEPROM Command Port

This block models the serial command side of a small byte-wide EEPROM that sits behind a four-wire SPI link in mode 0. It runs on the system clock. The chip-select, serial-clock and serial-data-in pins are synchronised and edge-detected in that clock domain. Instructions are decoded from whole bytes, and replies go out on a serial-data-out pin that has its own output enable, so a pad can tristate it.

The nonvolatile array is a flop array of `DEPTH` bytes, where `DEPTH` is a power of two of at least 64. Writes are collected in a 32-byte page buffer and are committed to the array only when a frame ends cleanly. A programmable cycle counter stands in for the program time. During that time a busy bit is set and only reads and status polling are useful. A status byte carries the busy bit, a write-enable latch and six user bits.

Top module: `serial_eeprom_port`

## Requirements
- R1: After reset the status byte reads 0x00, the data-out enable is low and every array byte reads 0x00.
- R2: Input bits are taken MSB first on rising serial-clock edges, and output bits change after falling edges. The instruction codes are 0x06 set-enable, 0x04 clear-enable, 0x05 read-status, 0x01 write-status, 0x03 read-array and 0x02 write-array.
- R3: A read-array frame is the instruction followed by a 16-bit address, high byte first, of which only the low log2(DEPTH) bits are used. The frame then returns consecutive bytes. After address DEPTH-1 the next byte comes from address 0.
- R4: Read-status returns a status byte with bit 0 = busy, bit 1 = write-enable latch and bits 7:2 = user bits. The byte is refreshed for every further byte clocked in the same frame.
- R5: The set-enable instruction sets the latch only when chip-select rises after exactly 8 bits. A frame with more bits leaves the latch unchanged. Clear-enable clears the latch.
- R6: A write-array frame sent while the latch is clear changes no array byte and starts no busy period.
- R7: Write data goes to consecutive addresses that wrap inside the 32-byte page selected by the address. A later byte in the same frame replaces an earlier byte at the same location.
- R8: A write frame commits only when chip-select rises on a whole-byte boundary after at least one data byte. Any other ending leaves the array unchanged, starts no busy period and keeps the latch.
- R9: A commit sets the busy bit for exactly WRITE_CYCLES clock cycles. The busy bit and the write-enable latch both clear when that period ends.
- R10: While the busy bit is set, set-enable, write-array and write-status are ignored, and read-status works.
- R11: Write-status needs the latch and one data byte ended on a byte boundary. It stores data bits 7:2 only, discards bits 1:0 and starts a busy period.
- R12: The data-out enable is high only while chip-select is low and the frame is in a data-returning phase: read-array after its address, or read-status after its instruction. It is low during instruction and address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock from the host, idle low |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data to the host |
| sdo_oe_o | output | 1 | Output enable for sdo_o |

## Verification
The checks assume that every level of the serial pins lasts several system clocks. The assumed pattern is: the serial clock changes only while chip-select is low, data-in is stable around each rising serial-clock edge, and the host leaves a gap after its last serial-clock fall before it raises chip-select. Under that pattern the synchroniser stages keep frame activity tied to the delayed chip-select level, and a commit can only come from a frame that already holds the latch while the device is idle. The bench drives every pin from tasks. Each pin level is held for six system clocks, which is more than the three-stage synchroniser delay, and output bits are sampled just before each rising serial-clock edge.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [7:0] OP_SET_EN  = 8'h06;
  localparam logic [7:0] OP_CLR_EN  = 8'h04;
  localparam logic [7:0] OP_RD_STAT = 8'h05;
  localparam logic [7:0] OP_WR_STAT = 8'h01;
  localparam logic [7:0] OP_RD_ARR  = 8'h03;
  localparam logic [7:0] OP_WR_ARR  = 8'h02;

  typedef enum logic [3:0] {
    PH_IDLE, PH_CMD, PH_AHI, PH_ALO, PH_RDAT,
    PH_WDAT, PH_SOUT, PH_SIN, PH_WEN, PH_IGN
  } phase_e;
endpackage

// File: rtl/eep_pin_sync.sv
module eep_pin_sync #(
  parameter int          N    = 3,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] prev_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [2:0] st_q;
    logic [2:0] st_d;
    always_comb st_d = {st_q[1:0], pin_i[g]};
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= {3{IDLE[g]}};
      else         st_q <= st_d;
    end
    assign lvl_o[g]  = st_q[1];
    assign prev_o[g] = st_q[2];
  end
endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
  parameter int CYC = 1500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic wip_o,
  output logic done_o
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)            cnt_d = CW'(CYC);
    else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign wip_o  = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1));
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int DEPTH = 256,
  parameter int PAGE  = 32,
  parameter int IW    = $clog2(DEPTH),
  parameter int PW    = $clog2(PAGE)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ld_i,
  input  logic [PW-1:0]    off_i,
  input  logic [7:0]       data_i,
  input  logic             commit_i,
  input  logic [IW-PW-1:0] page_i,
  input  logic [IW-1:0]    rd_idx_i,
  output logic [7:0]       rd_data_o
);
  logic [7:0]      mem_q  [DEPTH];
  logic [7:0]      pbuf_q [PAGE];
  logic [PAGE-1:0] pval_q, pval_d;

  always_comb begin
    pval_d = pval_q;
    if (clr_i)     pval_d = '0;
    else if (ld_i) pval_d[off_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pval_q <= '0;
    else         pval_q <= pval_d;
  end

  always_ff @(posedge clk_i) begin
    if (ld_i) pbuf_q[off_i] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (commit_i) begin
      for (int i = 0; i < PAGE; i++)
        if (pval_q[i]) mem_q[{page_i, PW'(i)}] <= pbuf_q[i];
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/eep_frame_ctrl.sv
module eep_frame_ctrl
  import eep_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int PAGE  = 32,
  parameter int IW    = $clog2(DEPTH),
  parameter int PW    = $clog2(PAGE)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic             sck_rise_i,
  input  logic             sck_fall_i,
  input  logic             sdi_i,
  input  logic             wip_i,
  input  logic             done_i,
  input  logic [7:0]       rd_data_i,
  output logic [IW-1:0]    rd_idx_o,
  output logic             buf_clr_o,
  output logic             buf_ld_o,
  output logic [PW-1:0]    buf_off_o,
  output logic [7:0]       buf_data_o,
  output logic             commit_o,
  output logic             start_o,
  output logic [IW-PW-1:0] page_o,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic             wel_o
);
  phase_e        ph_q, ph_d;
  logic          act_q, act_d;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    sh_q, sh_d;
  logic [7:0]    tx_q, tx_d;
  logic [7:0]    ahi_q, ahi_d;
  logic [IW-1:0] addr_q, addr_d;
  logic [5:0]    usr_q, usr_d;
  logic          got_q, got_d;
  logic          isrd_q, isrd_d;
  logic          ldp_q, ldp_d;
  logic          wel_q, wel_d;
  logic          sdo_q, sdo_d;

  logic [7:0]    byte_in;
  logic [15:0]   full_addr;
  logic [7:0]    status;
  logic [PW-1:0] off_nx;
  logic          unused_hi;

  assign byte_in   = {sh_q[6:0], sdi_i};
  assign full_addr = {ahi_q, byte_in};
  assign unused_hi = ^full_addr[15:IW];
  assign status    = {usr_q, wel_q, wip_i};
  assign off_nx    = addr_q[PW-1:0] + PW'(1);

  always_comb begin
    ph_d = ph_q; act_d = act_q; bit_d = bit_q; sh_d = sh_q; tx_d = tx_q;
    ahi_d = ahi_q; addr_d = addr_q; usr_d = usr_q; got_d = got_q;
    isrd_d = isrd_q; ldp_d = 1'b0; wel_d = wel_q; sdo_d = sdo_q;
    buf_clr_o = 1'b0; buf_ld_o = 1'b0; commit_o = 1'b0; start_o = 1'b0;

    if (cs_fall_i) begin
      act_d = 1'b1; ph_d = PH_CMD; bit_d = '0; got_d = 1'b0;
    end else if (cs_rise_i && act_q) begin
      act_d = 1'b0; ph_d = PH_IDLE;
      if (bit_q == '0 && got_q) begin
        unique case (ph_q)
          PH_WEN:  wel_d = 1'b1;
          PH_WDAT: begin commit_o = 1'b1; start_o = 1'b1; end
          PH_SIN:  begin usr_d = sh_q[7:2]; start_o = 1'b1; end
          default: ;
        endcase
      end
    end else if (sck_rise_i && act_q) begin
      sh_d  = byte_in;
      bit_d = bit_q + 3'd1;
      if ((ph_q == PH_WEN || ph_q == PH_SIN) && got_q) begin
        ph_d = PH_IGN;
      end else if (bit_q == 3'd7) begin
        unique case (ph_q)
          PH_CMD: begin
            unique case (byte_in)
              OP_SET_EN:  begin ph_d = wip_i ? PH_IGN : PH_WEN; got_d = 1'b1; end
              OP_CLR_EN:  begin wel_d = 1'b0; ph_d = PH_IGN; end
              OP_RD_STAT: begin ph_d = PH_SOUT; tx_d = status; end
              OP_WR_STAT: ph_d = (wip_i || !wel_q) ? PH_IGN : PH_SIN;
              OP_RD_ARR:  begin ph_d = PH_AHI; isrd_d = 1'b1; end
              OP_WR_ARR:  begin ph_d = PH_AHI; isrd_d = 1'b0; end
              default:    ph_d = PH_IGN;
            endcase
          end
          PH_AHI: begin ahi_d = byte_in; ph_d = PH_ALO; end
          PH_ALO: begin
            addr_d = full_addr[IW-1:0];
            if (isrd_q) begin
              ph_d = PH_RDAT; ldp_d = 1'b1;
            end else if (wel_q && !wip_i) begin
              ph_d = PH_WDAT; buf_clr_o = 1'b1;
            end else begin
              ph_d = PH_IGN;
            end
          end
          PH_RDAT: begin addr_d = addr_q + IW'(1); ldp_d = 1'b1; end
          PH_SOUT: tx_d = status;
          PH_WDAT: begin
            buf_ld_o = 1'b1; got_d = 1'b1;
            addr_d   = {addr_q[IW-1:PW], off_nx};
          end
          PH_SIN:  got_d = 1'b1;
          default: ;
        endcase
      end
    end else if (sck_fall_i && act_q && (ph_q == PH_RDAT || ph_q == PH_SOUT)) begin
      sdo_d = tx_q[7];
      tx_d  = {tx_q[6:0], 1'b0};
    end

    if (ldp_q)  tx_d  = rd_data_i;
    if (done_i) wel_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_IDLE; act_q <= 1'b0; bit_q <= '0; sh_q <= '0; tx_q <= '0;
      ahi_q <= '0; addr_q <= '0; usr_q <= '0; got_q <= 1'b0; isrd_q <= 1'b0;
      ldp_q <= 1'b0; wel_q <= 1'b0; sdo_q <= 1'b0;
    end else begin
      ph_q <= ph_d; act_q <= act_d; bit_q <= bit_d; sh_q <= sh_d; tx_q <= tx_d;
      ahi_q <= ahi_d; addr_q <= addr_d; usr_q <= usr_d; got_q <= got_d;
      isrd_q <= isrd_d; ldp_q <= ldp_d; wel_q <= wel_d; sdo_q <= sdo_d;
    end
  end

  assign rd_idx_o   = addr_q;
  assign buf_off_o  = addr_q[PW-1:0];
  assign buf_data_o = byte_in;
  assign page_o     = addr_q[IW-1:PW];
  assign sdo_o      = sdo_q;
  assign sdo_oe_o   = act_q && (ph_q == PH_RDAT || ph_q == PH_SOUT);
  assign wel_o      = wel_q;
endmodule

// File: rtl/serial_eeprom_port.sv
module serial_eeprom_port #(
  parameter int DEPTH        = 256,
  parameter int PAGE         = 32,
  parameter int WRITE_CYCLES = 1500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic sdi_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  localparam int IW = $clog2(DEPTH);
  localparam int PW = $clog2(PAGE);

  logic [1:0] rst_ff_q;
  logic       rst_n_sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_ff_q <= 2'b00;
    else         rst_ff_q <= {rst_ff_q[0], 1'b1};
  end
  assign rst_n_sync = rst_ff_q[1];

  // pin order: [0] chip select, [1] serial clock, [2] data in
  logic [2:0] pin_lvl, pin_prev;
  logic       unused_prev;
  eep_pin_sync #(.N(3), .IDLE(3'b001)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_n_sync), .pin_i({sdi_i, sck_i, cs_ni}),
    .lvl_o(pin_lvl), .prev_o(pin_prev)
  );
  assign unused_prev = pin_prev[2];

  logic cs_fall, cs_rise, sck_rise, sck_fall, cs_prev;
  assign cs_fall  = !pin_lvl[0] &&  pin_prev[0];
  assign cs_rise  =  pin_lvl[0] && !pin_prev[0];
  assign sck_rise =  pin_lvl[1] && !pin_prev[1];
  assign sck_fall = !pin_lvl[1] &&  pin_prev[1];
  assign cs_prev  = pin_prev[0];

  logic             wip, done, tmr_start, commit, buf_clr, buf_ld, wel;
  logic [IW-1:0]    rd_idx;
  logic [7:0]       rd_data, buf_data;
  logic [PW-1:0]    buf_off;
  logic [IW-PW-1:0] page;

  eep_frame_ctrl #(.DEPTH(DEPTH), .PAGE(PAGE)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_n_sync),
    .cs_fall_i(cs_fall), .cs_rise_i(cs_rise), .sck_rise_i(sck_rise), .sck_fall_i(sck_fall),
    .sdi_i(pin_lvl[2]), .wip_i(wip), .done_i(done), .rd_data_i(rd_data),
    .rd_idx_o(rd_idx), .buf_clr_o(buf_clr), .buf_ld_o(buf_ld), .buf_off_o(buf_off),
    .buf_data_o(buf_data), .commit_o(commit), .start_o(tmr_start), .page_o(page),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .wel_o(wel)
  );

  eep_store #(.DEPTH(DEPTH), .PAGE(PAGE)) u_store (
    .clk_i(clk_i), .rst_ni(rst_n_sync), .clr_i(buf_clr), .ld_i(buf_ld),
    .off_i(buf_off), .data_i(buf_data), .commit_i(commit), .page_i(page),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data)
  );

  eep_busy_timer #(.CYC(WRITE_CYCLES)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_n_sync), .start_i(tmr_start),
    .wip_o(wip), .done_o(done)
  );
endmodule

// File: rtl/eep_checker.sv
module eep_checker #(
  parameter int CYC = 1500
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sdo_oe,
  input logic cs_lvl,
  input logic wip,
  input logic wel,
  input logic commit,
  input logic start
);
  int unsigned run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  run_q <= 0;
    else if (wip) run_q <= run_q + 1;
    else          run_q <= 0;
  end

  p_oe_in_frame_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe |-> !cs_lvl);
  p_commit_needs_wel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> (wel && !wip));
  p_start_sets_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> wip);
  p_busy_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wip |-> (run_q < CYC));
  p_busy_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wip) |-> (run_q == CYC));
  p_wel_clear_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wip) |-> !wel);
  p_no_enable_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wip && !wel) |=> !wel);
endmodule

bind serial_eeprom_port eep_checker #(.CYC(WRITE_CYCLES)) u_eep_checker (
  .clk_i(clk_i), .rst_ni(rst_n_sync), .sdo_oe(sdo_oe_o), .cs_lvl(cs_prev),
  .wip(wip), .wel(wel), .commit(commit), .start(tmr_start)
);

// File: tb/serial_eeprom_port_bench.sv
module serial_eeprom_port_bench;
  localparam int DEPTH = 256;
  localparam int HALF  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  int total = 0, bad = 0;
  logic [7:0] model [DEPTH];

  always #2 clk = ~clk;

  serial_eeprom_port u_serial_eeprom_port (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic open_f();
    sck = 1'b0; cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic close_f();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic r);
    sdi = b;
    repeat (HALF) @(negedge clk);
    r = sdo; sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) bit_x(tx[i], rx[i]);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] d;
    open_f(); xfer(op, d); close_f();
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic [7:0] d;
    open_f(); xfer(8'h05, d); xfer(8'h00, s); close_f();
  endtask

  task automatic wait_idle(input string tag);
    logic [7:0] s;
    s = 8'h01;
    for (int k = 0; k < 60 && s[0]; k++) rd_status(s);
    chk({7'b0, s[0]}, 8'h00, tag);
  endtask

  task automatic write_seq(input logic [15:0] a, input int n, input logic [7:0] seed, input bit upd);
    logic [7:0] d;
    open_f(); xfer(8'h02, d); xfer(a[15:8], d); xfer(a[7:0], d);
    for (int k = 0; k < n; k++) begin
      xfer(seed + 8'(k), d);
      if (upd) model[{a[7:5], 5'(a[4:0] + 5'(k))}] = seed + 8'(k);
    end
    close_f();
  endtask

  task automatic read_chk(input logic [15:0] a, input int n, input string tag);
    logic [7:0] d;
    open_f(); xfer(8'h03, d); xfer(a[15:8], d); xfer(a[7:0], d);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, d);
      chk(d, model[8'(a[7:0] + 8'(k))], tag);
    end
    close_f();
  endtask

  // R1 reset state
  task automatic t_reset();
    logic [7:0] s;
    chk({7'b0, sdo_oe}, 8'h00, "R1 oe after reset");
    rd_status(s); chk(s, 8'h00, "R1 R4 status after reset");
    read_chk(16'h0010, 2, "R1 R2 array zero");
  endtask

  // R5 enable latch framing
  task automatic t_enable();
    logic [7:0] s, d;
    open_f(); xfer(8'h06, d); xfer(8'h00, d); close_f();
    rd_status(s); chk(s, 8'h00, "R5 long set-enable ignored");
    cmd(8'h06); rd_status(s); chk(s, 8'h02, "R5 set-enable");
    cmd(8'h04); rd_status(s); chk(s, 8'h00, "R5 clear-enable");
  endtask

  // R6 write without latch
  task automatic t_no_latch();
    logic [7:0] s;
    write_seq(16'h0010, 1, 8'hAB, 1'b0);
    rd_status(s); chk(s, 8'h00, "R6 no busy");
    read_chk(16'h0010, 1, "R6 array unchanged");
  endtask

  // R7 R9 page writes and busy period
  task automatic t_page();
    logic [7:0] s;
    cmd(8'h06); write_seq(16'h001E, 3, 8'hC0, 1'b1);
    rd_status(s); chk(s, 8'h03, "R9 busy and latch during write");
    wait_idle("R9 busy ends"); rd_status(s); chk(s, 8'h00, "R9 latch cleared at end");
    read_chk(16'h001E, 2, "R7 page tail"); read_chk(16'h0000, 1, "R7 page wrap to start");
    cmd(8'h06); write_seq(16'h0040, 34, 8'h01, 1'b1); wait_idle("R9 busy ends long");
    read_chk(16'h0040, 32, "R7 overwrite within page");
  endtask

  // R8 aborted write
  task automatic t_abort();
    logic [7:0] s, d;
    logic r;
    cmd(8'h06);
    open_f(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h80, d); xfer(8'h77, d);
    for (int k = 0; k < 4; k++) bit_x(1'b1, r);
    close_f();
    rd_status(s); chk(s, 8'h02, "R8 no busy latch kept");
    read_chk(16'h0080, 1, "R8 array unchanged");
    cmd(8'h04);
  endtask

  // R10 commands during busy
  task automatic t_busy();
    logic [7:0] s;
    cmd(8'h06); write_seq(16'h00A0, 1, 8'h11, 1'b1);
    write_seq(16'h00A1, 1, 8'h22, 1'b0);
    cmd(8'h06);
    rd_status(s); chk({7'b0, s[0]}, 8'h01, "R10 status readable while busy");
    wait_idle("R10 busy ends");
    rd_status(s); chk(s, 8'h00, "R10 set-enable ignored while busy");
    read_chk(16'h00A0, 2, "R10 write ignored while busy");
  endtask

  // R3 rollover
  task automatic t_roll();
    cmd(8'h06); write_seq(16'h00FF, 1, 8'h5A, 1'b1); wait_idle("R3 busy ends");
    read_chk(16'h00FF, 3, "R3 address rollover");
  endtask

  // R12 output enable
  task automatic t_oe();
    logic [7:0] d;
    open_f(); xfer(8'h03, d);
    chk({7'b0, sdo_oe}, 8'h00, "R12 oe low in address");
    xfer(8'h00, d); xfer(8'h10, d);
    repeat (HALF) @(negedge clk);
    chk({7'b0, sdo_oe}, 8'h01, "R12 oe high in data");
    close_f();
    chk({7'b0, sdo_oe}, 8'h00, "R12 oe low after frame");
  endtask

  // R11 R4 status writes
  task automatic t_wrsr();
    logic [7:0] s, s2, d;
    cmd(8'h06);
    open_f(); xfer(8'h01, d); xfer(8'hFF, d); close_f();
    rd_status(s); chk(s, 8'hFF, "R11 user bits busy latch");
    wait_idle("R11 busy ends");
    open_f(); xfer(8'h05, d); xfer(8'h00, s); xfer(8'h00, s2); close_f();
    chk(s, 8'hFC, "R11 low bits discarded");
    chk(s2, 8'hFC, "R4 status repeated");
    open_f(); xfer(8'h01, d); xfer(8'h00, d); close_f();
    rd_status(s); chk(s, 8'hFC, "R11 write-status needs latch");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset(); t_enable(); t_no_latch(); t_page(); t_abort();
    t_busy(); t_roll(); t_oe(); t_wrsr();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R9 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule